// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Per-Channel Clock Divider

This block generates four independent pulse-width modulated outputs from a single clock. Software programs each channel through a plain word-wide register port: a control word carries an enable flag, an output polarity flag and a 10-bit clock divider, and two further words set the cycle length and the active length, both counted in divided clock ticks.

A running channel steps an internal counter once every divider clock cycles. The counter runs from zero to one below the programmed period and then starts again. The output is active while the counter is below the duty value. The polarity flag chooses whether active means a high or a low level. Clearing the enable flag parks the channel at its inactive level with its counters at zero. Setting the flag again starts a new cycle from count zero.

Top module: `pwm_quad_ctrl`

## Requirements
- R1: There are four channels. Channel i (0 to 3) owns the byte offsets (i+1)*0x10 to (i+1)*0x10+0xF. Within that range the control word is at +0x0, the period at +0x4 and the duty at +0x8. Reads of any other word, including offsets 0x00 to 0x0F, a channel's +0xC and anything from 0x50 up, return zero. Writes to those words change no register.
- R2: In the control word, bit 0 is enable, bit 1 is polarity and bits 11:2 are the divider. All other bits read as zero. Period and duty are 16 bits each, and their upper 16 bits read as zero. Reads are combinational from the address. A write takes effect at the clock edge on which the write enable is sampled high.
- R3: After a synchronous active-low reset, every register reads zero and every output sits at the inactive level for polarity 0, which is high.
- R4: Each counter step lasts D clock cycles, where D is the divider value. A divider of 0 behaves as 1.
- R5: With period P greater than 0, the counter repeats the values 0 to P-1, so one output cycle lasts P*D clock cycles. With P equal to 0, the counter stays at 0.
- R6: In the k-th cycle after the enabling write's edge (k=0 being the cycle right after that edge), the channel is active when ((k/D) mod P) is less than the duty value.
- R7: A duty of at least P gives a constantly active output. A duty of 0 gives a constantly inactive output.
- R8: With polarity 1 the output is high when active. With polarity 0 the output is low when active.
- R9: A disabled channel drives its inactive level and holds its counters at zero. Enabling it again starts a new cycle at k=0.
- R10: Channels run independently. Writing to one channel does not change the registers or the waveform of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for the register port and the waveforms |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 8 | Byte address of the register word |
| we | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at `addr`, combinational |
| pwm_o | output | 4 | One waveform output per channel |

## Verification
The bench uses the default parameters: four channels, a 10-bit divider, 16-bit period and duty, and an 8-bit address. It programs only small values: dividers 0 to 3 and periods 1 to 5, with every duty from 0 to period+1 under both polarities. This keeps each waveform short enough to compare cycle by cycle against an arithmetic model over two full output cycles. The sweep therefore reaches the zero-divider case and both ends of the duty range. A run with three channels started at staggered times, a disable and re-enable sequence, and reads and writes of unmapped words cover channel independence, restart from count zero and address decoding.

// File: rtl/pwm_pkg.sv
// Package: field encodings shared by the address decoder and the register read mux.
// Assumes word-aligned accesses; the two low address bits are not decoded.
package pwm_pkg;

    // Word select inside one channel bank (address bits 3:2).
    typedef enum logic [1:0] {
        FLD_CTRL   = 2'd0,
        FLD_PERIOD = 2'd1,
        FLD_DUTY   = 2'd2,
        FLD_NONE   = 2'd3
    } pwm_fld_e;

    // Byte stride between channel banks, as an address bit count.
    localparam int BANK_SHIFT = 4;

endpackage

// File: rtl/pwm_addr_dec.sv
// Module: pwm_addr_dec
// Turns a byte address into a one-hot channel select and a word select.
// Bank 0 is empty. Channel i is selected by bank i+1, and banks above NUM_CH select nothing.
module pwm_addr_dec
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ch_sel,
    output pwm_fld_e          fld
);

    localparam int BANK_W = ADDR_W - BANK_SHIFT;

    logic [BANK_W-1:0] bank;

    assign bank = addr[ADDR_W-1:BANK_SHIFT];

    // One compare per channel against its bank number.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        assign ch_sel[i] = (bank == BANK_W'(i + 1));
    end

    // Word select from address bits 3:2.
    always_comb begin
        fld = pwm_fld_e'(addr[3:2]);
    end

endmodule

// File: rtl/pwm_channel.sv
// Module: pwm_channel
// One PWM channel: its control, period and duty registers, the divider counter,
// the period counter and the polarity stage.
// Assumes write strobes are already qualified by the address decode.
module pwm_channel #(
    parameter int DIV_W  = 10,
    parameter int PER_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_per,
    input  logic              wr_duty,
    input  logic [DATA_W-1:0] wdata,
    output logic [DIV_W+1:0]  ctrl_rd,
    output logic [PER_W-1:0]  per_rd,
    output logic [PER_W-1:0]  duty_rd,
    output logic              pwm_o
);

    logic             en_q;
    logic             pol_q;
    logic [DIV_W-1:0] div_q;
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] duty_q;
    logic [DIV_W-1:0] pre_q;
    logic [PER_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_eff;
    logic             pre_last;
    logic             cnt_last;
    logic             active;

    // Register writes, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            pol_q  <= 1'b0;
            div_q  <= '0;
            per_q  <= '0;
            duty_q <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q  <= wdata[0];
                pol_q <= wdata[1];
                div_q <= wdata[DIV_W+1:2];
            end
            if (wr_per)  per_q  <= wdata[PER_W-1:0];
            if (wr_duty) duty_q <= wdata[PER_W-1:0];
        end
    end

    // A divider of zero runs as one.
    assign div_eff  = (div_q == '0) ? DIV_W'(1) : div_q;
    assign pre_last = (pre_q >= div_eff - DIV_W'(1));
    assign cnt_last = (per_q == '0) || (cnt_q >= per_q - PER_W'(1));

    // Divider and period counters, held at zero while the channel is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_q) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (pre_last) begin
            pre_q <= '0;
            cnt_q <= cnt_last ? '0 : cnt_q + PER_W'(1);
        end else begin
            pre_q <= pre_q + DIV_W'(1);
        end
    end

    // Active level while the count is below duty, then the polarity stage.
    assign active = en_q && (cnt_q < duty_q);
    assign pwm_o  = pol_q ? active : !active;

    assign ctrl_rd = {div_q, pol_q, en_q};
    assign per_rd  = per_q;
    assign duty_rd = duty_q;

    AST_PRE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && pre_q >= div_eff) |=> (pre_q == '0));  // R4

    AST_STEP_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q) && cnt_q != $past(cnt_q)) |-> (pre_q == '0));  // R4

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !$past(en_q)) |-> (pre_q == '0 && cnt_q == '0));  // R9

    AST_PER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_per |=> (per_rd == $past(wdata[PER_W-1:0])));  // R2

endmodule

// File: rtl/pwm_quad_ctrl.sv
// Module: pwm_quad_ctrl
// Top level: address decode, NUM_CH channel instances and the read-data mux.
// Assumes one clock for the bus and the waveforms and word-aligned accesses.
module pwm_quad_ctrl
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 10,
    parameter int PER_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] pwm_o
);

    localparam int CTRL_W = DIV_W + 2;
    localparam int BANK_W = ADDR_W - BANK_SHIFT;

    logic [NUM_CH-1:0] ch_sel;
    pwm_fld_e          fld;
    logic [CTRL_W-1:0] ctrl_rd [NUM_CH];
    logic [PER_W-1:0]  per_rd  [NUM_CH];
    logic [PER_W-1:0]  duty_rd [NUM_CH];

    pwm_addr_dec #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr   (addr),
        .ch_sel (ch_sel),
        .fld    (fld)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm_channel #(
            .DIV_W  (DIV_W),
            .PER_W  (PER_W),
            .DATA_W (DATA_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (we && ch_sel[i] && fld == FLD_CTRL),
            .wr_per  (we && ch_sel[i] && fld == FLD_PERIOD),
            .wr_duty (we && ch_sel[i] && fld == FLD_DUTY),
            .wdata   (wdata),
            .ctrl_rd (ctrl_rd[i]),
            .per_rd  (per_rd[i]),
            .duty_rd (duty_rd[i]),
            .pwm_o   (pwm_o[i])
        );
    end

    // Read mux: the selected channel's word, zero-extended; zero for anything unmapped.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_sel[i]) begin
                case (fld)
                    FLD_CTRL:   rdata = DATA_W'(ctrl_rd[i]);
                    FLD_PERIOD: rdata = DATA_W'(per_rd[i]);
                    FLD_DUTY:   rdata = DATA_W'(duty_rd[i]);
                    default:    rdata = '0;
                endcase
            end
        end
    end

    AST_RD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[ADDR_W-1:BANK_SHIFT] == '0 || addr[ADDR_W-1:BANK_SHIFT] > BANK_W'(NUM_CH))
        |-> (rdata == '0));  // R1

endmodule

// File: tb/pwm_quad_ctrl_test.sv
module pwm_quad_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm_o;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;  // 50 MHz

    pwm_quad_ctrl uut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .we    (we),
        .wdata (wdata),
        .rdata (rdata),
        .pwm_o (pwm_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one write; returns at the falling edge right after the write edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        chk(rdata, exp, tag);
    endtask

    // Output level k cycles after enabling.
    function automatic logic exp_out(input int k, input int dv, input int p,
                                     input int du, input int pol);
        int d;
        int c;
        logic act;
        d   = (dv == 0) ? 1 : dv;
        c   = (p == 0) ? 0 : ((k / d) % p);
        act = (c < du);
        return (pol != 0) ? act : !act;
    endfunction

    function automatic logic [7:0] base(input int ch);
        return 8'((ch + 1) * 16);
    endfunction

    // Program one channel from disabled, enable it, compare the waveform.
    task automatic run_cfg(input int ch, input int dv, input int p, input int du,
                           input int pol, input int ncyc);
        string tag;
        if (dv == 0)                 tag = "R4";
        else if (du == 0 || du >= p) tag = "R7";
        else if (pol == 0)           tag = "R8";
        else                         tag = "R6";
        wr(base(ch), 32'(pol) << 1);
        wr(base(ch) + 8'h4, 32'(p));
        wr(base(ch) + 8'h8, 32'(du));
        wr(base(ch), (32'(dv) << 2) | (32'(pol) << 1) | 32'h1);
        for (int k = 0; k < ncyc; k++) begin
            chk({31'b0, pwm_o[ch]}, {31'b0, exp_out(k, dv, p, du, pol)}, tag);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state
        chk({28'b0, pwm_o}, 32'hF, "R3");
        for (int ch = 0; ch < 4; ch++) begin
            rd_chk(base(ch),        32'h0, "R3");
            rd_chk(base(ch) + 8'h4, 32'h0, "R3");
            rd_chk(base(ch) + 8'h8, 32'h0, "R3");
        end

        // R2: field widths and readback
        wr(base(0),        32'hFFFF_FFFE);
        wr(base(0) + 8'h4, 32'hABCD_1234);
        wr(base(0) + 8'h8, 32'hFFFF_5678);
        rd_chk(base(0),        32'h0000_0FFE, "R2");
        rd_chk(base(0) + 8'h4, 32'h0000_1234, "R2");
        rd_chk(base(0) + 8'h8, 32'h0000_5678, "R2");
        chk({31'b0, pwm_o[0]}, 32'h0, "R8");

        // R1: unmapped words read zero and ignore writes
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'hF4, 32'hFFFF_FFFF);
        rd_chk(8'h00, 32'h0, "R1");
        rd_chk(8'h0C, 32'h0, "R1");
        rd_chk(8'h1C, 32'h0, "R1");
        rd_chk(8'h50, 32'h0, "R1");
        rd_chk(8'hF4, 32'h0, "R1");
        rd_chk(base(0),        32'h0000_0FFE, "R1");
        rd_chk(base(0) + 8'h4, 32'h0000_1234, "R1");
        for (int ch = 1; ch < 4; ch++) begin
            rd_chk(base(ch),        32'h0, "R1");
            rd_chk(base(ch) + 8'h8, 32'h0, "R1");
        end
        chk({28'b0, pwm_o}, 32'hE, "R10");

        // R4..R8: sweep divider, period, duty, polarity on channel 0
        for (int pol = 0; pol < 2; pol++)
            for (int dv = 0; dv < 4; dv++)
                for (int p = 1; p <= 5; p++)
                    for (int du = 0; du <= p + 1; du++)
                        run_cfg(0, dv, p, du, pol, 2 * p * ((dv == 0) ? 1 : dv) + 3);

        // R5: period zero holds count at zero
        run_cfg(0, 2, 0, 1, 1, 12);
        run_cfg(0, 1, 0, 0, 1, 6);
        wr(base(0), 32'h2);  // disable, polarity 1

        // R10: three channels started two cycles apart
        wr(base(1) + 8'h4, 32'd3); wr(base(1) + 8'h8, 32'd1);
        wr(base(2) + 8'h4, 32'd5); wr(base(2) + 8'h8, 32'd4);
        wr(base(3) + 8'h4, 32'd4); wr(base(3) + 8'h8, 32'd2);
        wr(base(1), (32'd2 << 2) | 32'h3);
        wr(base(2), (32'd1 << 2) | 32'h1);
        wr(base(3), (32'd3 << 2) | 32'h3);
        for (int k = 0; k < 40; k++) begin
            chk({31'b0, pwm_o[3]}, {31'b0, exp_out(k,     3, 4, 2, 1)}, "R10");
            chk({31'b0, pwm_o[2]}, {31'b0, exp_out(k + 2, 1, 5, 4, 0)}, "R10");
            chk({31'b0, pwm_o[1]}, {31'b0, exp_out(k + 4, 2, 3, 1, 1)}, "R10");
            chk({31'b0, pwm_o[0]}, 32'h0, "R9");
            @(negedge clk);
        end

        // R9: disable mid-run, hold inactive, restart from count zero
        wr(base(3), (32'd3 << 2) | 32'h2);
        for (int k = 0; k < 5; k++) begin
            chk({31'b0, pwm_o[3]}, 32'h0, "R9");
            @(negedge clk);
        end
        rd_chk(base(3), (32'd3 << 2) | 32'h2, "R9");
        wr(base(3), (32'd3 << 2) | 32'h3);
        for (int k = 0; k < 26; k++) begin
            chk({31'b0, pwm_o[3]}, {31'b0, exp_out(k, 3, 4, 2, 1)}, "R9");
            @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule